// File: doc/BRIEF.md
# Split-Aware Deskew Marker Strobe Generator

This block sits on the transmit side of a 16-lane link that can be split into independent narrower links. Every 16 clock cycles it raises a one-cycle strobe that tells the transmit datapath to put a deskew marker on its lanes. The datapath and the marker symbol itself are handled elsewhere. Each 8-lane octet carries its own 2-bit split setting, so the two octets may be split differently. The split decides which of the octet's four marker groups fire. A whole-width link or an 8-lane link uses group 0. Two 4-lane links use groups 0 and 2. Four 2-lane links use all four groups. Single-lane links get no markers.

The block has a free-running period counter that is cleared by reset. At the edge where this counter wraps, the block samples the split inputs and loads the group strobes into a register. Per-lane strobes are then fanned out from the registered groups. All active groups in both octets fire in the same cycle. A split change between two wraps has no effect until the next wrap.

Top module: `dskew_mark_gen`

## Requirements
- R1: While reset is asserted, and until the first counter wrap after reset is released, every group strobe and every lane strobe is low.
- R2: Strobes are high only in the single cycle that follows each wrap edge. The wrap edges are the 16th rising edge after reset release and every 16th edge after that. In all other cycles the strobes are low.
- R3: Split code 2'b00 (one 8-lane link, or one half of a 16-lane link) strobes only group index 0 of that octet, so its 4-bit group mask is 4'b0001.
- R4: Split code 2'b01 (two 4-lane links) strobes group indices 0 and 2 of that octet, mask 4'b0101.
- R5: Split code 2'b10 (four 2-lane links) strobes all four group indices 0 to 3, mask 4'b1111.
- R6: Split code 2'b11 (single-lane links) strobes no group and no lane of that octet.
- R7: Each octet follows its own split code. Octet o takes its code from `oct_split_i[2*o+1:2*o]` and drives `grp_stb_o[4*o+3:4*o]`, so mixed splits produce each octet's own mask.
- R8: Local lane j of an octet (j = 0..7) strobes exactly when its covering group strobes. With split 2'b00 that is group 0. With split 2'b01 it is group 0 for j < 4 and group 2 otherwise. With split 2'b10 it is group j/2. Lane strobe bit index is 8*o + j.
- R9: The split inputs are sampled only at the wrap edge. Any value they hold in other cycles has no effect on the strobes.
- R10: On a wrap, all active groups of both octets are strobed in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| oct_split_i | input | 4 | Per-octet split code, 2 bits per octet |
| grp_stb_o | output | 8 | Marker group strobes, 4 per octet |
| lane_stb_o | output | 16 | Per-lane marker insert strobes |

## Verification
A strobe is due in the cycle after the 16th rising edge following reset release, and again every 16 edges after that. It carries the mask of the split code that was present at that same edge. The lane strobes use the same cycle, because they are combinational from the group register. The bench counts rising edges from reset release and samples 2 ns after each edge. It drives split changes only after that sample, so the code seen at each wrap edge is always known. A different, scrambled code is held for most of each period to show that only the wrap-edge value matters.

// File: rtl/dskew_mark_pkg.sv
package dskew_mark_pkg;

   localparam int GRP_PER_OCT = 4;

   typedef enum logic [1:0] {
      SPLIT_X8 = 2'b00,
      SPLIT_X4 = 2'b01,
      SPLIT_X2 = 2'b10,
      SPLIT_X1 = 2'b11
   } split_e;

   function automatic logic [GRP_PER_OCT-1:0] split_to_grp(input split_e s);
      logic [GRP_PER_OCT-1:0] m;
      case (s)
         SPLIT_X8: m = 4'b0001;
         SPLIT_X4: m = 4'b0101;
         SPLIT_X2: m = 4'b1111;
         default:  m = 4'b0000;
      endcase
      return m;
   endfunction

endpackage

// File: rtl/dskew_period_ctr.sv
module dskew_period_ctr #(
   parameter int PERIOD = 16
) (
   input  logic clk,
   input  logic rst_n,
   output logic wrap_o
);
   localparam int CNT_W = (PERIOD > 2) ? $clog2(PERIOD) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (cnt_q == LAST) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // High in the cycle whose closing edge wraps the counter
   assign wrap_o = (cnt_q == LAST);

endmodule

// File: rtl/dskew_grp_decode.sv
module dskew_grp_decode
   import dskew_mark_pkg::*;
(
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wrap_i,
   input  logic [1:0]             split_i,
   output logic [GRP_PER_OCT-1:0] grp_o
);
   logic [GRP_PER_OCT-1:0] grp_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         grp_q <= '0;
      end else if (wrap_i) begin
         grp_q <= split_to_grp(split_e'(split_i));
      end else begin
         grp_q <= '0;
      end
   end

   assign grp_o = grp_q;

endmodule

// File: rtl/dskew_lane_fanout.sv
module dskew_lane_fanout
   import dskew_mark_pkg::*;
#(
   parameter int OCTET_W = 8
) (
   input  logic [GRP_PER_OCT-1:0] grp_i,
   output logic [OCTET_W-1:0]     lane_o
);
   localparam int HALF_W    = OCTET_W / 2;
   localparam int QUARTER_W = OCTET_W / 4;

   for (genvar j = 0; j < OCTET_W; j++) begin : g_lane
      localparam int HALF_GRP = (j / HALF_W) * 2;
      localparam int QTR_GRP  = j / QUARTER_W;
      // Only one split is active at a time, so OR-ing the candidate groups
      // picks the one that covers this lane.
      assign lane_o[j] = grp_i[0] | grp_i[HALF_GRP] | grp_i[QTR_GRP];
   end

endmodule

// File: rtl/dskew_mark_gen.sv
module dskew_mark_gen
   import dskew_mark_pkg::*;
#(
   parameter int NUM_OCTETS = 2,
   parameter int OCTET_W    = 8,
   parameter int PERIOD     = 16,
   localparam int LANES     = NUM_OCTETS * OCTET_W,
   localparam int GRPS      = NUM_OCTETS * GRP_PER_OCT
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [2*NUM_OCTETS-1:0] oct_split_i,
   output logic [GRPS-1:0]         grp_stb_o,
   output logic [LANES-1:0]        lane_stb_o
);

   if (OCTET_W < 4 || (OCTET_W % 4) != 0) begin : g_bad_octet
      $error("dskew_mark_gen: OCTET_W must be a positive multiple of 4");
   end
   if (PERIOD < 2) begin : g_bad_period
      $error("dskew_mark_gen: PERIOD must be at least 2");
   end
   if (NUM_OCTETS < 1) begin : g_bad_octets
      $error("dskew_mark_gen: NUM_OCTETS must be at least 1");
   end

   logic wrap;

   dskew_period_ctr #(.PERIOD(PERIOD)) ctr_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .wrap_o (wrap)
   );

   for (genvar o = 0; o < NUM_OCTETS; o++) begin : g_oct
      logic [GRP_PER_OCT-1:0] grp;

      dskew_grp_decode dec_i (
         .clk     (clk),
         .rst_n   (rst_n),
         .wrap_i  (wrap),
         .split_i (oct_split_i[2*o +: 2]),
         .grp_o   (grp)
      );

      dskew_lane_fanout #(.OCTET_W(OCTET_W)) fan_i (
         .grp_i  (grp),
         .lane_o (lane_stb_o[o*OCTET_W +: OCTET_W])
      );

      assign grp_stb_o[o*GRP_PER_OCT +: GRP_PER_OCT] = grp;
   end

endmodule

// File: rtl/dskew_mark_gen_chk.sv
module dskew_mark_gen_chk
   import dskew_mark_pkg::*;
#(
   parameter int NUM_OCTETS = 2,
   parameter int OCTET_W    = 8,
   parameter int PERIOD     = 16
) (
   input logic                              clk,
   input logic                              rst_n,
   input logic [2*NUM_OCTETS-1:0]           oct_split_i,
   input logic [NUM_OCTETS*GRP_PER_OCT-1:0] grp_stb_o,
   input logic [NUM_OCTETS*OCTET_W-1:0]     lane_stb_o
);
   localparam int CW = (PERIOD > 2) ? $clog2(PERIOD) : 1;

   logic [CW-1:0] ck_cnt;
   logic          ck_wrapped;

   // Independent cycle count since reset release
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ck_cnt     <= '0;
         ck_wrapped <= 1'b0;
      end else if (ck_cnt == CW'(PERIOD - 1)) begin
         ck_cnt     <= '0;
         ck_wrapped <= 1'b1;
      end else begin
         ck_cnt <= ck_cnt + 1'b1;
      end
   end

   // R2: strobes only in the cycle after a wrap edge
   a_r2_phase: assert property (@(posedge clk) disable iff (!rst_n)
      (grp_stb_o != '0) |-> (ck_cnt == '0 && ck_wrapped));

   // R2: a strobe lasts one cycle
   a_r2_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (grp_stb_o != '0) |=> (grp_stb_o == '0));

   // R1: lanes silent until the first wrap
   a_r1_quiet_start: assert property (@(posedge clk) disable iff (!rst_n)
      !ck_wrapped |-> (lane_stb_o == '0));

   for (genvar o = 0; o < NUM_OCTETS; o++) begin : g_oct_chk
      // R6: single-lane split yields no strobe
      a_r6_x1_silent: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(oct_split_i[2*o +: 2]) == 2'b11) |->
            (grp_stb_o[o*GRP_PER_OCT +: GRP_PER_OCT] == '0));

      // R3: every active split includes group 0
      a_r3_base_grp: assert property (@(posedge clk) disable iff (!rst_n)
         (grp_stb_o[o*GRP_PER_OCT +: GRP_PER_OCT] != '0) |->
            grp_stb_o[o*GRP_PER_OCT]);

      // R8: lanes of an octet all move together
      a_r8_lane_cover: assert property (@(posedge clk) disable iff (!rst_n)
         ($countones(lane_stb_o[o*OCTET_W +: OCTET_W]) == 0) ||
         ($countones(lane_stb_o[o*OCTET_W +: OCTET_W]) == OCTET_W));

      // R10: when any octet fires, every non-x1 octet fires too
      a_r10_same_cycle: assert property (@(posedge clk) disable iff (!rst_n)
         ((grp_stb_o != '0) && ($past(oct_split_i[2*o +: 2]) != 2'b11)) |->
            grp_stb_o[o*GRP_PER_OCT]);
   end

endmodule

bind dskew_mark_gen dskew_mark_gen_chk #(
   .NUM_OCTETS (NUM_OCTETS),
   .OCTET_W    (OCTET_W),
   .PERIOD     (PERIOD)
) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .oct_split_i (oct_split_i),
   .grp_stb_o   (grp_stb_o),
   .lane_stb_o  (lane_stb_o)
);

// File: tb/dskew_mark_gen_tb.sv
module dskew_mark_gen_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  oct_split_i = 4'd0;
   logic [7:0]  grp_stb_o;
   logic [15:0] lane_stb_o;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   dskew_mark_gen dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .oct_split_i (oct_split_i),
      .grp_stb_o   (grp_stb_o),
      .lane_stb_o  (lane_stb_o)
   );

   // Group mask from split code: groups stepped by 4 >> code, none for code 3
   function automatic logic [3:0] exp_grp(input logic [1:0] m);
      logic [3:0] r = '0;
      if (m != 2'b11) begin
         for (int g = 0; g < 4; g++) begin
            if ((g % (4 >> m)) == 0) r[g] = 1'b1;
         end
      end
      return r;
   endfunction

   // Lane covered by group: x8 -> 0, x4 -> (j/4)*2, x2 -> j/2
   function automatic logic [7:0] exp_lane(input logic [1:0] m, input logic [3:0] g);
      logic [7:0] r = '0;
      for (int j = 0; j < 8; j++) begin
         case (m)
            2'b00: r[j] = g[0];
            2'b01: r[j] = g[(j / 4) * 2];
            2'b10: r[j] = g[j / 2];
            default: r[j] = 1'b0;
         endcase
      end
      return r;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [3:0] at_edge;
      logic [3:0] target;
      logic [3:0] eg;
      // R1: quiet during reset
      repeat (3) begin
         @(posedge clk);
         #2;
         chk("R1 in reset grp", 32'(grp_stb_o), 32'h0);
         chk("R1 in reset lane", 32'(lane_stb_o), 32'h0);
      end
      #1 rst_n = 1'b1;
      for (int k = 1; k <= 17 * 16; k++) begin
         @(posedge clk);
         at_edge = oct_split_i;
         #2;
         if (k < 16) begin
            chk("R1 before first wrap", {8'h0, lane_stb_o, grp_stb_o}, 32'h0);
         end else if ((k % 16) != 0) begin
            chk("R2 off cycle", {8'h0, lane_stb_o, grp_stb_o}, 32'h0);
         end else begin
            for (int o = 0; o < 2; o++) begin
               logic [1:0] m;
               m  = at_edge[2*o +: 2];
               eg = exp_grp(m);
               case (m)
                  2'b00: chk("R3 x8 group mask", 32'(grp_stb_o[4*o +: 4]), 32'(eg));
                  2'b01: chk("R4 x4 group mask", 32'(grp_stb_o[4*o +: 4]), 32'(eg));
                  2'b10: chk("R5 x2 group mask", 32'(grp_stb_o[4*o +: 4]), 32'(eg));
                  default: chk("R6 x1 no groups", 32'(grp_stb_o[4*o +: 4]), 32'(eg));
               endcase
               if (m == 2'b11)
                  chk("R6 x1 no lanes", 32'(lane_stb_o[8*o +: 8]), 32'h0);
               chk("R8 lane fanout", 32'(lane_stb_o[8*o +: 8]), 32'(exp_lane(m, eg)));
            end
            if (at_edge[1:0] != at_edge[3:2])
               chk("R7 mixed split", 32'(grp_stb_o),
                   32'({exp_grp(at_edge[3:2]), exp_grp(at_edge[1:0])}));
            chk("R10 both octets same cycle", 32'(grp_stb_o),
                32'({exp_grp(at_edge[3:2]), exp_grp(at_edge[1:0])}));
            chk("R9 only wrap-edge code used", 32'(grp_stb_o),
                32'({exp_grp(target[3:2]), exp_grp(target[1:0])}));
         end
         // Next wrap at k rounded up to 16; it tests combo (wrap/16 - 1) % 16
         target = 4'(((k / 16) + ((k % 16) == 0 ? 0 : 1) - 1 + 16) % 16);
         if ((k % 16) == 2) oct_split_i = target + 4'd5;
         if ((k % 16) == 15) oct_split_i = target;
      end
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule